// File: doc/BRIEF.md
# Retriggerable Mute Timer

This block produces a mute indication that stays asserted for a fixed interval after each tuning change. A control word is shifted in elsewhere and latched. At the latch the block samples a timer-request bit and a two-bit mode field. When the mode field selects normal operation and the request bit is set, the status output leaves its idle level on the latch cycle and holds the active level for a set number of ticks of a slow reference strobe. A tick rate of 50 Hz and the default of 15 ticks give about 300 ms.

The one-shot can be retriggered. A further request latch restarts a full interval. A latch with the request bit clear leaves a running pulse to finish on its own. After reset the block is busy for one full interval. During that window it ignores requests and holds the output idle.

Top module: `mute_timer`

## Requirements
- R1: While reset is asserted, and from reset release until INTERVAL_TICKS tick strobes have been seen, the output is at its idle level.
- R2: A request latch during the post-reset busy window has no effect. The output stays idle, and the busy window still ends after INTERVAL_TICKS ticks counted from reset.
- R3: Once the busy window has ended, a qualifying latch starts a pulse.
- R4: A latch with the request bit high and mode field 2'b00 puts the output at its active level from the clock edge that samples the latch. No tick is needed.
- R5: A pulse started with no later latch stays active through INTERVAL_TICKS-1 ticks and returns to idle at the edge that samples tick number INTERVAL_TICKS.
- R6: A latch whose mode field is 2'b01, 2'b10 or 2'b11 has no effect on the timer. It neither starts a pulse nor extends a running one.
- R7: A latch with the request bit low (mode 2'b00) does not shorten a running pulse. The pulse ends at its original tick.
- R8: A qualifying latch during a running pulse reloads the full interval. The pulse ends INTERVAL_TICKS ticks after that latch.
- R9: When a qualifying latch and a tick arrive in the same cycle, the latch wins. The full interval is loaded and that tick is not counted.
- R10: With ACTIVE_HIGH=1 the idle level is 0 and the active level is 1. With ACTIVE_HIGH=0 both levels are inverted.
- R11: Ticks while idle with no latch leave the output idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| latchStb | input | 1 | One-cycle strobe marking that a new control word was latched |
| reqBit | input | 1 | Timer-request bit of the latched word |
| modeSel | input | 2 | Mode field of the latched word; 2'b00 is normal operation |
| tickStb | input | 1 | One-cycle strobe per period of the slow reference |
| statusOut | output | 1 | Mute status at the level chosen by ACTIVE_HIGH |

## Verification
The patterns applied are these:
- A single undisturbed pulse fixes the exact tick on which the output returns to idle.
- A mid-pulse retrigger separates a full reload from a simple extension or no effect.
- A mid-pulse latch with the request bit clear shows whether a running pulse is cut short.
- Latches in each test mode, both while idle and mid-pulse, show whether the mode gate is respected.
- Requests during the post-reset busy window, and a latch that coincides with a tick, probe the priority corners.
- A second instance with inverted polarity is compared on every cycle.

// File: rtl/mute_pkg.sv
package mute_pkg;
  typedef struct packed {
    logic load;
    logic dec;
  } cntCmd_t;

  localparam logic [1:0] MODE_NORMAL = 2'b00;
endpackage

// File: rtl/mute_count.sv
module mute_count
  import mute_pkg::*;
#(
  parameter int INTERVAL_TICKS = 15,
  localparam int CW = $clog2(INTERVAL_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  cntCmd_t       cmd,
  output logic [CW-1:0] cntVal,
  output logic          cntZero,
  output logic          cntOne
);
  localparam logic [CW-1:0] FULL = CW'(INTERVAL_TICKS);

  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         count <= FULL;
    else if (cmd.load) count <= FULL;
    else if (cmd.dec)  count <= count - 1'b1;
  end

  assign cntVal  = count;
  assign cntZero = (count == '0);
  assign cntOne  = (count == CW'(1));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec |-> count != '0);

  // R8
  load_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> count == FULL);
endmodule

// File: rtl/mute_ctrl.sv
module mute_ctrl
  import mute_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       latchStb,
  input  logic       reqBit,
  input  logic [1:0] modeSel,
  input  logic       tickStb,
  input  logic       cntZero,
  input  logic       cntOne,
  output cntCmd_t    cmd,
  output logic       busy,
  output logic       pulseOn
);
  logic trigger;
  logic busyDone;

  assign trigger  = latchStb && reqBit && (modeSel == MODE_NORMAL) && !busy;
  assign busyDone = busy && tickStb && cntOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busy <= 1'b1;
    else if (busyDone) busy <= 1'b0;
  end

  always_comb begin
    cmd.load = trigger;
    cmd.dec  = tickStb && !cntZero && !trigger;
  end

  assign pulseOn = !busy && !cntZero;

  // R1
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(tickStb && cntOne)) |=> busy);

  // R2
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmd.load);
endmodule

// File: rtl/mute_timer.sv
module mute_timer
  import mute_pkg::*;
#(
  parameter int INTERVAL_TICKS = 15,
  parameter bit ACTIVE_HIGH    = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       latchStb,
  input  logic       reqBit,
  input  logic [1:0] modeSel,
  input  logic       tickStb,
  output logic       statusOut
);
  localparam int   CW       = $clog2(INTERVAL_TICKS + 1);
  localparam logic IDLE_LVL = ACTIVE_HIGH ? 1'b0 : 1'b1;

  cntCmd_t       cmd;
  logic [CW-1:0] cntVal;
  logic          cntZero, cntOne, busy, pulseOn;

  mute_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .latchStb(latchStb), .reqBit(reqBit),
    .modeSel(modeSel), .tickStb(tickStb), .cntZero(cntZero),
    .cntOne(cntOne), .cmd(cmd), .busy(busy), .pulseOn(pulseOn)
  );

  mute_count #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_count (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cntVal(cntVal),
    .cntZero(cntZero), .cntOne(cntOne)
  );

  generate
    if (ACTIVE_HIGH) begin : g_pos
      assign statusOut = pulseOn;
    end else begin : g_neg
      assign statusOut = !pulseOn;
    end
  endgenerate

  // R2
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> statusOut == IDLE_LVL);

  // R4
  start_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchStb && reqBit && modeSel == 2'b00 && !busy) |=> statusOut != IDLE_LVL);

  // R6
  mode_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchStb && modeSel != 2'b00 && !tickStb) |=> $stable(cntVal));

  // R7
  clear_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchStb && !reqBit && !tickStb) |=> $stable(cntVal));
endmodule

// File: tb/sim_mute_timer.sv
module sim_mute_timer;
  localparam int TK = 15;

  typedef struct {
    logic  expv;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic latchStb = 1'b0, reqBit = 1'b0, tickStb = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic statusOut, statusInv;

  int nChk = 0, nFail = 0;
  item_t sbq[$];

  always #5 clk = ~clk;

  mute_timer #(.INTERVAL_TICKS(TK), .ACTIVE_HIGH(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .latchStb(latchStb), .reqBit(reqBit),
    .modeSel(modeSel), .tickStb(tickStb), .statusOut(statusOut));

  mute_timer #(.INTERVAL_TICKS(TK), .ACTIVE_HIGH(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .latchStb(latchStb), .reqBit(reqBit),
    .modeSel(modeSel), .tickStb(tickStb), .statusOut(statusInv));

  task automatic check(input logic act, input logic expv, input string tag);
    nChk++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", tag, act, expv);
    end
  endtask

  // driver: one cycle of stimulus plus the expected output after the edge
  task automatic cyc(input logic l, input logic r, input logic [1:0] m,
                     input logic t, input logic expv, input string tag);
    item_t it;
    @(negedge clk);
    latchStb = l; reqBit = r; modeSel = m; tickStb = t;
    it.expv = expv; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic ticks(input int n, input logic expv, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'b00, 1'b1, expv, tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  // monitor: compare each expected item shortly after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(statusOut, it.expv, it.tag);
        check(statusInv, ~it.expv, "R10 inverted polarity");
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(statusOut, 1'b0, "R1 reset idle");
    check(statusInv, 1'b1, "R10 reset idle inverted");
    rstN = 1'b1;
    // R2: requests ignored while busy
    cyc(1, 1, 2'b00, 0, 0, "R2 trigger in busy");
    ticks(TK - 1, 0, "R1 busy window");
    cyc(1, 1, 2'b00, 0, 0, "R2 late trigger in busy");
    ticks(1, 0, "R2 busy ends idle");
    // R11: idle ticks
    ticks(2, 0, "R11 idle ticks");
    // R3/R4/R5: single pulse
    cyc(1, 1, 2'b00, 0, 1, "R4 R3 trigger on latch edge");
    ticks(TK - 1, 1, "R5 pulse held");
    cyc(0, 0, 2'b00, 0, 1, "R5 pulse held no tick");
    ticks(1, 0, "R5 pulse ends");
    // R6: test modes while idle
    cyc(1, 1, 2'b01, 0, 0, "R6 mode 01");
    cyc(1, 1, 2'b10, 0, 0, "R6 mode 10");
    cyc(1, 1, 2'b11, 0, 0, "R6 mode 11");
    ticks(2, 0, "R6 idle after test mode");
    // R7: clear latch mid pulse
    cyc(1, 1, 2'b00, 0, 1, "R7 start");
    ticks(5, 1, "R7 running");
    cyc(1, 0, 2'b00, 0, 1, "R7 clear latch");
    ticks(TK - 6, 1, "R7 still running");
    ticks(1, 0, "R7 original end");
    // R8: retrigger
    cyc(1, 1, 2'b00, 0, 1, "R8 start");
    ticks(10, 1, "R8 running");
    cyc(1, 1, 2'b00, 0, 1, "R8 retrigger");
    ticks(TK - 1, 1, "R8 extended");
    ticks(1, 0, "R8 ends after full reload");
    // R6: test-mode latch mid pulse does not extend
    cyc(1, 1, 2'b00, 0, 1, "R6 start");
    ticks(3, 1, "R6 running");
    cyc(1, 1, 2'b10, 0, 1, "R6 test latch mid pulse");
    ticks(TK - 4, 1, "R6 running");
    ticks(1, 0, "R6 not extended");
    // R9: latch and tick together
    cyc(1, 1, 2'b00, 0, 1, "R9 start");
    ticks(5, 1, "R9 running");
    cyc(1, 1, 2'b00, 1, 1, "R9 latch with tick");
    ticks(TK - 1, 1, "R9 full reload");
    ticks(1, 0, "R9 end");
    cyc(0, 0, 2'b00, 0, 0, "R11 idle");
    @(posedge clk);
    @(posedge clk);
    #3;
    summary();
    $finish;
  end
endmodule